// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the byte-wide arithmetic and logic unit of an accumulator machine. Each cycle in which the enable is high, it takes the accumulator value, a second operand byte, the current flag byte and a five-bit operation code. It then registers a new accumulator value and a new flag byte. The flag byte holds sign, zero, auxiliary carry, parity and carry. The surrounding datapath normally feeds the registered flags back into the flag input, so carry-in, borrow-in and the decimal-adjust history come from the previous operation.

Each operation updates the flags by its own rule. Rotates change only the carry. Compare leaves the accumulator as it was. Decimal adjust runs a low-digit correction and then a high-digit correction. The complement operations leave every other flag alone. Logic operations clear carry. Increment and decrement keep carry. Reset must be asserted asynchronously and released synchronously to `clk`, with the synchronizer outside the block.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, `acc_q` and `flags_q` read 0x00. The flag byte places sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R2: While `en_i` is low, `acc_q` and `flags_q` keep their values whatever the other inputs do.
- R3: ADD (code 0) and ADC (code 1) register acc+opnd, and ADC also adds the incoming carry. Carry takes the carry out of bit 7, and auxiliary carry takes the carry out of bit 3.
- R4: SUB (code 2) and SBB (code 3) register acc-opnd, and SBB also subtracts the incoming carry. Carry is set on an unsigned borrow. Auxiliary carry is set on a borrow out of the low four bits.
- R5: CMP (code 7) sets every flag exactly as SUB would and registers the accumulator input unchanged.
- R6: AND (code 4), XOR (code 5) and OR (code 6) register the bitwise result and clear both carry and auxiliary carry.
- R7: For codes 0–9 and 14, sign equals bit 7 of the computed result, zero is set when that result is 0x00, and parity is set when it holds an even number of ones.
- R8: INC (code 8) and DEC (code 9) add or subtract one and keep the incoming carry. Auxiliary carry marks a carry or borrow across bit 3.
- R9: RLC (code 10) rotates left, copying bit 7 into bit 0 and into carry. RRC (code 11) rotates right, copying bit 0 into bit 7 and into carry. All other flags pass through.
- R10: RAL (code 12) rotates left through carry and RAR (code 13) rotates right through carry, each taking the old carry into the vacated bit. All other flags pass through.
- R11: DAA (code 14) adds 6 when the low digit exceeds 9 or auxiliary carry is set, with auxiliary carry taking that carry out of bit 3. It then adds 0x60 when the resulting high digit exceeds 9, the step overflowed, or carry was set. Carry is set exactly when the high step applied.
- R12: CMA (code 15) registers the inverted accumulator, and the flag byte passes through unchanged.
- R13: CMC (code 16) inverts only carry and STC (code 17) sets only carry. The accumulator input passes through.
- R14: Codes 18–31 register the accumulator input and the flag input unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| en_i | input | 1 | Clock enable; one operation per enabled cycle |
| op_i | input | 5 | Operation code |
| acc_i | input | DW | Accumulator value before the operation |
| opnd_i | input | DW | Second operand byte |
| flags_i | input | 8 | Flag byte before the operation |
| acc_q | output | DW | Registered accumulator result |
| flags_q | output | 8 | Registered flag byte |

## Verification
Both output registers load one clock after an enabled cycle, so any error in carry selection, nibble-carry extraction or decimal correction appears at the ports on the first following edge. Wrong state here shows up as a flag bit that differs from the hand-worked value. Examples are a zero flag raised by a rotate, carry lost across increment, or an auxiliary carry taken from the wrong step of decimal adjust. The vectors are chosen so that every carry source is exercised at both polarities.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,
    OP_ADC = 5'd1,
    OP_SUB = 5'd2,
    OP_SBB = 5'd3,
    OP_AND = 5'd4,
    OP_XOR = 5'd5,
    OP_OR  = 5'd6,
    OP_CMP = 5'd7,
    OP_INC = 5'd8,
    OP_DEC = 5'd9,
    OP_RLC = 5'd10,
    OP_RRC = 5'd11,
    OP_RAL = 5'd12,
    OP_RAR = 5'd13,
    OP_DAA = 5'd14,
    OP_CMA = 5'd15,
    OP_CMC = 5'd16,
    OP_STC = 5'd17
  } alu_op_e;

  localparam int FLW  = 8;
  localparam int F_CY = 0;
  localparam int F_P  = 2;
  localparam int F_AC = 4;
  localparam int F_Z  = 6;
  localparam int F_S  = 7;
  localparam logic [FLW-1:0] FLAG_MASK = 8'hD5;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          cy_o,
  output logic          hc_o
);
  logic [DW-1:0] b_eff;
  logic          c_eff;
  logic [DW:0]   full;
  logic [NIB:0]  low;

  always_comb begin
    b_eff = sub_i ? ~b_i : b_i;
    c_eff = sub_i ? ~cin_i : cin_i;
    full  = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, c_eff};
    low   = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    res_o = full[DW-1:0];
    // subtraction reports borrow, the inverse of the adder carry
    cy_o  = sub_i ? ~full[DW] : full[DW];
    hc_o  = sub_i ? ~low[NIB] : low[NIB];
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops #(
  parameter int DW = 8
) (
  input  alu_pkg::alu_op_e op_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  input  logic             cy_i,
  output logic [DW-1:0]    res_o,
  output logic             cy_o
);
  import alu_pkg::*;

  always_comb begin
    res_o = a_i;
    cy_o  = cy_i;
    case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_RLC: begin
        res_o = {a_i[DW-2:0], a_i[DW-1]};
        cy_o  = a_i[DW-1];
      end
      OP_RRC: begin
        res_o = {a_i[0], a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      OP_RAL: begin
        res_o = {a_i[DW-2:0], cy_i};
        cy_o  = a_i[DW-1];
      end
      OP_RAR: begin
        res_o = {cy_i, a_i[DW-1:1]};
        cy_o  = a_i[0];
      end
      OP_CMA: res_o = ~a_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_bcd_adj.sv
module alu_bcd_adj #(
  parameter int DW  = 8,
  parameter int NIB = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic          ac_i,
  input  logic          cy_i,
  output logic [DW-1:0] res_o,
  output logic          ac_o,
  output logic          cy_o
);
  localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
  localparam logic [NIB-1:0] DIG_FIX = NIB'(6);

  logic          lo_fix;
  logic          hi_fix;
  logic [NIB:0]  lo_sum;
  logic [DW:0]   step1;

  always_comb begin
    lo_fix = (a_i[NIB-1:0] > DIG_MAX) | ac_i;
    lo_sum = {1'b0, a_i[NIB-1:0]} + (lo_fix ? {1'b0, DIG_FIX} : '0);
    step1  = {1'b0, a_i} + (lo_fix ? (DW+1)'(DIG_FIX) : '0);
    // high digit is judged after the low correction has been applied
    hi_fix = cy_i | step1[DW] | (step1[2*NIB-1:NIB] > DIG_MAX);
    res_o  = step1[DW-1:0] + (hi_fix ? (DW'(DIG_FIX) << NIB) : '0);
    ac_o   = lo_sum[NIB];
    cy_o   = hi_fix;
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en_i,
  input  logic [4:0]            op_i,
  input  logic [DW-1:0]         acc_i,
  input  logic [DW-1:0]         opnd_i,
  input  logic [alu_pkg::FLW-1:0] flags_i,
  output logic [DW-1:0]         acc_q,
  output logic [alu_pkg::FLW-1:0] flags_q
);
  import alu_pkg::*;

  localparam int NIB = 4;

  alu_op_e        op;
  logic [DW-1:0]  as_b;
  logic           as_cin;
  logic           as_sub;
  logic [DW-1:0]  as_res;
  logic           as_cy;
  logic           as_hc;
  logic [DW-1:0]  bit_res;
  logic           bit_cy;
  logic [DW-1:0]  bcd_res;
  logic           bcd_ac;
  logic           bcd_cy;
  logic [DW-1:0]  szp_src;
  logic [FLW-1:0] szp;
  logic [DW-1:0]  acc_nx;
  logic [FLW-1:0] flg_nx;

  assign op = alu_op_e'(op_i);

  // operand steering for the shared adder/subtractor
  always_comb begin
    as_b   = opnd_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    case (op)
      OP_ADC: as_cin = flags_i[F_CY];
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_SBB: begin
        as_sub = 1'b1;
        as_cin = flags_i[F_CY];
      end
      OP_INC: as_b = DW'(1);
      OP_DEC: begin
        as_b   = DW'(1);
        as_sub = 1'b1;
      end
      default: ;
    endcase
  end

  alu_addsub #(.DW(DW), .NIB(NIB)) u_addsub (
    .a_i(acc_i), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .res_o(as_res), .cy_o(as_cy), .hc_o(as_hc)
  );

  alu_bitops #(.DW(DW)) u_bitops (
    .op_i(op), .a_i(acc_i), .b_i(opnd_i), .cy_i(flags_i[F_CY]),
    .res_o(bit_res), .cy_o(bit_cy)
  );

  alu_bcd_adj #(.DW(DW), .NIB(NIB)) u_bcd (
    .a_i(acc_i), .ac_i(flags_i[F_AC]), .cy_i(flags_i[F_CY]),
    .res_o(bcd_res), .ac_o(bcd_ac), .cy_o(bcd_cy)
  );

  // sign / zero / parity from whichever result feeds the flags
  always_comb begin
    case (op)
      OP_AND, OP_XOR, OP_OR: szp_src = bit_res;
      OP_DAA:                szp_src = bcd_res;
      default:               szp_src = as_res;
    endcase
    szp        = '0;
    szp[F_S]   = szp_src[DW-1];
    szp[F_Z]   = (szp_src == '0);
    szp[F_P]   = ~^szp_src;
  end

  // next-state selection
  always_comb begin
    acc_nx = acc_i;
    flg_nx = flags_i & FLAG_MASK;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB: begin
        acc_nx       = as_res;
        flg_nx       = szp;
        flg_nx[F_AC] = as_hc;
        flg_nx[F_CY] = as_cy;
      end
      OP_CMP: begin
        flg_nx       = szp;
        flg_nx[F_AC] = as_hc;
        flg_nx[F_CY] = as_cy;
      end
      OP_INC, OP_DEC: begin
        acc_nx       = as_res;
        flg_nx       = szp;
        flg_nx[F_AC] = as_hc;
        flg_nx[F_CY] = flags_i[F_CY];
      end
      OP_AND, OP_XOR, OP_OR: begin
        acc_nx = bit_res;
        flg_nx = szp;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
        acc_nx       = bit_res;
        flg_nx[F_CY] = bit_cy;
      end
      OP_DAA: begin
        acc_nx       = bcd_res;
        flg_nx       = szp;
        flg_nx[F_AC] = bcd_ac;
        flg_nx[F_CY] = bcd_cy;
      end
      OP_CMA: acc_nx = bit_res;
      OP_CMC: flg_nx[F_CY] = ~flags_i[F_CY];
      OP_STC: flg_nx[F_CY] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
    end else if (en_i) begin
      acc_q   <= acc_nx;
      flags_q <= flg_nx;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    en_i,
  input logic [4:0]              op_i,
  input logic [DW-1:0]           acc_i,
  input logic [DW-1:0]           opnd_i,
  input logic [alu_pkg::FLW-1:0] flags_i,
  input logic [DW-1:0]           acc_q,
  input logic [alu_pkg::FLW-1:0] flags_q
);
  import alu_pkg::*;

  logic szp_op;
  assign szp_op = (op_i <= 5'd9) || (op_i == 5'd14);

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~FLAG_MASK) == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(acc_q) && $stable(flags_q)));

  a_r5_cmp_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i == 5'd7) |=> acc_q == $past(acc_i));

  a_r6_logic_clears_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i >= 5'd4 && op_i <= 5'd6) |=> (!flags_q[F_CY] && !flags_q[F_AC]));

  a_r7_zero_matches: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && szp_op && op_i != 5'd7) |=>
      (flags_q[F_Z] == (acc_q == '0)) && (flags_q[F_S] == acc_q[DW-1]) &&
      (flags_q[F_P] == ~^acc_q));

  a_r8_incdec_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (op_i == 5'd8 || op_i == 5'd9)) |=> flags_q[F_CY] == $past(flags_i[F_CY]));

  a_r9_rlc_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i == 5'd10) |=>
      (acc_q == {$past(acc_i[DW-2:0]), $past(acc_i[DW-1])}) &&
      (flags_q[F_CY] == $past(acc_i[DW-1])));

  a_r12_cma_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && op_i == 5'd15) |=>
      (acc_q == ~$past(acc_i)) && (flags_q == ($past(flags_i) & FLAG_MASK)));

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .acc_i(acc_i),
  .opnd_i(opnd_i), .flags_i(flags_i), .acc_q(acc_q), .flags_q(flags_q)
);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

  logic       clk;
  logic       rst_n;
  logic       en_i;
  logic [4:0] op_i;
  logic [7:0] acc_i;
  logic [7:0] opnd_i;
  logic [7:0] flags_i;
  logic [7:0] acc_q;
  logic [7:0] flags_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  acc_alu #(.DW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .op_i(op_i), .acc_i(acc_i),
    .opnd_i(opnd_i), .flags_i(flags_i), .acc_q(acc_q), .flags_q(flags_q)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] ea, input logic [7:0] ef);
    checks++;
    if (acc_q !== ea || flags_q !== ef) begin
      errors++;
      $display("FAIL %s: acc=%02h flags=%02h expected acc=%02h flags=%02h",
               req, acc_q, flags_q, ea, ef);
    end
  endtask

  task automatic run(input string req, input logic [4:0] op, input logic [7:0] a,
                     input logic [7:0] b, input logic [7:0] f,
                     input logic [7:0] ea, input logic [7:0] ef);
    @(negedge clk);
    en_i = 1'b1; op_i = op; acc_i = a; opnd_i = b; flags_i = f;
    @(posedge clk);
    @(negedge clk);
    en_i = 1'b0;
    check(req, ea, ef);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en_i = 1'b1; op_i = 5'd0; acc_i = 8'h12; opnd_i = 8'h34; flags_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R1 reset", 8'h00, 8'h00);
    en_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_add();
    run("R3 add carry and half carry", 5'd0, 8'h3A, 8'hC6, 8'h00, 8'h00, 8'h55);
    run("R3 adc uses carry in",        5'd1, 8'h14, 8'h22, 8'h01, 8'h37, 8'h00);
  endtask

  task automatic t_sub();
    run("R4 sub borrow",        5'd2, 8'h10, 8'h20, 8'h00, 8'hF0, 8'h85);
    run("R4 sbb low borrow",    5'd3, 8'h50, 8'h0F, 8'h01, 8'h40, 8'h10);
  endtask

  task automatic t_cmp();
    run("R5 cmp equal",   5'd7, 8'h42, 8'h42, 8'h00, 8'h42, 8'h44);
    run("R5 cmp below",   5'd7, 8'h05, 8'h06, 8'h00, 8'h05, 8'h95);
  endtask

  task automatic t_logic();
    run("R6 and clears cy ac", 5'd4, 8'hF0, 8'h3C, 8'h11, 8'h30, 8'h04);
    run("R6 R7 xor to zero",   5'd5, 8'h55, 8'h55, 8'h01, 8'h00, 8'h44);
    run("R6 R7 or sign",       5'd6, 8'h80, 8'h01, 8'h01, 8'h81, 8'h84);
  endtask

  task automatic t_incdec();
    run("R8 inc wrap keeps cy", 5'd8, 8'hFF, 8'h00, 8'h01, 8'h00, 8'h55);
    run("R8 dec wrap keeps cy", 5'd9, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h94);
  endtask

  task automatic t_rot();
    run("R9 rlc",            5'd10, 8'h81, 8'h00, 8'hC4, 8'h03, 8'hC5);
    run("R9 rrc",            5'd11, 8'h02, 8'h00, 8'h01, 8'h01, 8'h00);
    run("R10 ral no zero",   5'd12, 8'h80, 8'h00, 8'h00, 8'h00, 8'h01);
    run("R10 ral carry in",  5'd12, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
    run("R10 rar",           5'd13, 8'h01, 8'h00, 8'h00, 8'h00, 8'h01);
    run("R10 rar carry in",  5'd13, 8'h00, 8'h00, 8'h01, 8'h80, 8'h00);
  endtask

  task automatic t_daa();
    run("R11 daa both digits", 5'd14, 8'h9B, 8'h00, 8'h00, 8'h01, 8'h11);
    run("R11 daa ac forces",   5'd14, 8'h15, 8'h00, 8'h10, 8'h1B, 8'h04);
    run("R11 daa no change",   5'd14, 8'h42, 8'h00, 8'h00, 8'h42, 8'h04);
    run("R11 daa cy forces",   5'd14, 8'h00, 8'h00, 8'h01, 8'h60, 8'h05);
  endtask

  task automatic t_cmpl();
    run("R12 cma",            5'd15, 8'h5A, 8'h00, 8'hFF, 8'hA5, 8'hD5);
    run("R13 cmc",            5'd16, 8'h33, 8'h00, 8'h95, 8'h33, 8'h94);
    run("R13 stc",            5'd17, 8'h33, 8'h00, 8'h00, 8'h33, 8'h01);
    run("R14 unused code",    5'd20, 8'h77, 8'h12, 8'hFF, 8'h77, 8'hD5);
  endtask

  task automatic t_hold();
    run("R2 setup", 5'd0, 8'h01, 8'h01, 8'h00, 8'h02, 8'h00);
    @(negedge clk);
    en_i = 1'b0; op_i = 5'd15; acc_i = 8'hFF; opnd_i = 8'hFF; flags_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R2 hold while disabled", 8'h02, 8'h00);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: acc=%02h flags=%02h expected run to end", acc_q, flags_q);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_logic();
    t_incdec();
    t_rot();
    t_daa();
    t_cmpl();
    t_hold();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule